// File: doc/BRIEF.md
# Configuration-Register Instruction Decoder

This block is the issue-side decoder of a compact-instruction DSP engine. Each 24-bit instruction carries an opcode, a 3-bit selector and an operand field. The selector names one of eight 128-bit configuration registers, and those registers are loaded ahead of use through a separate write port. At issue, the decoder joins the instruction fields with the selected wide configuration word into a single registered control bundle for the execution units.

A write to a configuration register in the same cycle as an instruction that selects that register is forwarded, so the bundle carries the new word. The block also derives a vector of unit enables. It takes this vector from the low bits of the selected word, and clears it when the opcode is zero, which marks a no-op.

Top module: `cfg_issue_decoder`

## Requirements
- R1: While reset is asserted and right after it, bundle_valid, every bundle field and unit_en are zero, and all eight configuration registers read as zero.
- R2: The instruction is split as opcode = insn[23:16], selector = insn[15:13] and operands = insn[12:0]. These values appear on bundle_opcode, bundle_sel and bundle_operands.
- R3: bundle_valid is high in the cycle after a clock edge at which insn_valid was high, and low after an edge at which insn_valid was low.
- R4: bundle_cfg carries the contents of the configuration register named by the selector of the issued instruction.
- R5: When cfg_we is high at a clock edge, cfg_wdata is stored in the register addressed by cfg_waddr (0 to 7). All other registers keep their contents.
- R6: If cfg_we is high and cfg_waddr equals the selector of a valid instruction in the same cycle, the bundle carries cfg_wdata and not the old register value.
- R7: An instruction with opcode 0 is a no-op. It still issues a valid bundle with its fields and configuration word, but unit_en is all zero.
- R8: For a nonzero opcode, unit_en equals bits [7:0] of the issued configuration word.
- R9: After an edge with insn_valid low, all bundle fields and unit_en keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction present this cycle |
| insn | input | 24 | Instruction word |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_waddr | input | 3 | Configuration register being written |
| cfg_wdata | input | 128 | Configuration word to store |
| bundle_valid | output | 1 | Issued bundle is valid |
| bundle_opcode | output | 8 | Issued opcode |
| bundle_sel | output | 3 | Issued selector |
| bundle_operands | output | 13 | Issued operand field |
| bundle_cfg | output | 128 | Issued configuration word |
| unit_en | output | 8 | Execution-unit enables |

## Verification
A configuration register that holds a wrong word shows up in bundle_cfg and unit_en one cycle after the first instruction that selects it. Until then it is invisible, so the bench reads every register back through issue after each kind of write. A broken forwarding path, or a selector decoded from the wrong bits, shows at the very next bundle. A missing hold or a bad valid register shows in the cycle right after an idle edge.

// File: rtl/cfg_issue_decoder.sv
module cfg_issue_decoder #(
  parameter int INSN_W  = 24,
  parameter int OPC_W   = 8,
  parameter int NUM_CFG = 8,
  parameter int CFG_W   = 128,
  parameter int UNITS   = 8,
  localparam int SEL_W  = $clog2(NUM_CFG),
  localparam int OPND_W = INSN_W - OPC_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [INSN_W-1:0] insn,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_waddr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              bundle_valid,
  output logic [OPC_W-1:0]  bundle_opcode,
  output logic [SEL_W-1:0]  bundle_sel,
  output logic [OPND_W-1:0] bundle_operands,
  output logic [CFG_W-1:0]  bundle_cfg,
  output logic [UNITS-1:0]  unit_en
);

  logic [CFG_W-1:0] cfg_q [NUM_CFG];

  logic [OPC_W-1:0]  dec_opc;
  logic [SEL_W-1:0]  dec_sel;
  logic [OPND_W-1:0] dec_opnd;
  logic              fwd_hit;
  logic [CFG_W-1:0]  sel_cfg;
  logic [UNITS-1:0]  en_next;

  assign dec_opc  = insn[INSN_W-1 -: OPC_W];
  assign dec_sel  = insn[OPND_W +: SEL_W];
  assign dec_opnd = insn[OPND_W-1:0];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg_q[g] <= '0;
      else if (cfg_we && cfg_waddr == SEL_W'(g))
        cfg_q[g] <= cfg_wdata;
    end
  end

  assign fwd_hit = cfg_we && (cfg_waddr == dec_sel);
  assign sel_cfg = fwd_hit ? cfg_wdata : cfg_q[dec_sel];
  assign en_next = (dec_opc != '0) ? sel_cfg[UNITS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bundle_valid    <= 1'b0;
      bundle_opcode   <= '0;
      bundle_sel      <= '0;
      bundle_operands <= '0;
      bundle_cfg      <= '0;
      unit_en         <= '0;
    end else begin
      bundle_valid <= insn_valid;
      if (insn_valid) begin
        bundle_opcode   <= dec_opc;
        bundle_sel      <= dec_sel;
        bundle_operands <= dec_opnd;
        bundle_cfg      <= sel_cfg;
        unit_en         <= en_next;
      end
    end
  end

  AST_ISSUE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid |=> bundle_valid); // R3
  AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> !bundle_valid); // R3
  AST_FIELD_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid |=> bundle_opcode == $past(insn[23:16]) && bundle_sel == $past(insn[15:13])); // R2
  AST_FORWARD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && cfg_we && cfg_waddr == insn[15:13]) |=> bundle_cfg == $past(cfg_wdata)); // R6
  AST_NOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[23:16] == '0) |=> unit_en == '0); // R7
  AST_EN_FROM_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (bundle_valid && bundle_opcode != '0) |-> unit_en == bundle_cfg[UNITS-1:0]); // R8
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> $stable(bundle_cfg) && $stable(bundle_operands) && $stable(unit_en)); // R9

endmodule

// File: tb/sim_cfg_issue_decoder.sv
module sim_cfg_issue_decoder;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         insn_valid = 1'b0;
  logic [23:0]  insn = '0;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_waddr = '0;
  logic [127:0] cfg_wdata = '0;
  logic         bundle_valid;
  logic [7:0]   bundle_opcode;
  logic [2:0]   bundle_sel;
  logic [12:0]  bundle_operands;
  logic [127:0] bundle_cfg;
  logic [7:0]   unit_en;

  int n_cmp = 0;
  int n_bad = 0;
  logic [127:0] model [8];

  always #5 clk = ~clk;

  cfg_issue_decoder u0 (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .bundle_valid(bundle_valid), .bundle_opcode(bundle_opcode),
    .bundle_sel(bundle_sel), .bundle_operands(bundle_operands),
    .bundle_cfg(bundle_cfg), .unit_en(unit_en)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] pat(input int k);
    return {32'hC0DE0000 | 32'(k), 32'h5A5A0000 ^ 32'(k * 7), 32'h01234567 + 32'(k), 24'hABCDEF, 8'(8'h11 * k + 8'h3)};
  endfunction

  // One cycle: drive at negedge, check after the following posedge.
  task automatic step(input logic v, input logic [7:0] op, input logic [2:0] sel, input logic [12:0] opnd,
                      input logic we, input logic [2:0] wa, input logic [127:0] wd);
    @(negedge clk);
    insn_valid = v; insn = {op, sel, opnd};
    cfg_we = we; cfg_waddr = wa; cfg_wdata = wd;
    @(posedge clk); #1;
    if (we) model[wa] = wd;
  endtask

  task automatic idle_inputs();
    @(negedge clk);
    insn_valid = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic check_bundle(input string req, input logic [7:0] op, input logic [2:0] sel,
                              input logic [12:0] opnd, input logic [127:0] cfg);
    chk({req, " valid"}, 128'(bundle_valid), 128'(1'b1));
    chk({req, " opcode"}, 128'(bundle_opcode), 128'(op));
    chk({req, " sel"}, 128'(bundle_sel), 128'(sel));
    chk({req, " operands"}, 128'(bundle_operands), 128'(opnd));
    chk({req, " cfg"}, bundle_cfg, cfg);
    chk({req, " unit_en"}, 128'(unit_en), (op == 8'h00) ? 128'(0) : 128'(cfg[7:0]));
  endtask

  task automatic t_reset();
    @(posedge clk); #1;
    chk("R1 valid in reset", 128'(bundle_valid), 128'(0));
    chk("R1 cfg in reset", bundle_cfg, 128'(0));
    chk("R1 unit_en in reset", 128'(unit_en), 128'(0));
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 8'h01, 3'(k), 13'h0, 1'b0, 3'd0, '0);
      check_bundle("R1 register reads zero", 8'h01, 3'(k), 13'h0, 128'(0));
    end
    idle_inputs();
  endtask

  task automatic t_preload_select();
    for (int k = 0; k < 8; k++) step(1'b0, 8'h00, 3'd0, 13'h0, 1'b1, 3'(k), pat(k));
    for (int k = 7; k >= 0; k--) begin
      step(1'b1, 8'h40 + 8'(k), 3'(k), 13'(k * 333), 1'b0, 3'd0, '0);
      check_bundle("R4 R8 select", 8'h40 + 8'(k), 3'(k), 13'(k * 333), model[k]);
    end
    idle_inputs();
  endtask

  task automatic t_fields();
    step(1'b1, 8'hFF, 3'd5, 13'h1FFF, 1'b0, 3'd0, '0);
    check_bundle("R2 all ones", 8'hFF, 3'd5, 13'h1FFF, model[5]);
    step(1'b1, 8'h80, 3'd2, 13'h1000, 1'b0, 3'd0, '0);
    check_bundle("R2 high bits", 8'h80, 3'd2, 13'h1000, model[2]);
    step(1'b1, 8'h01, 3'd1, 13'h0001, 1'b0, 3'd0, '0);
    check_bundle("R2 low bits", 8'h01, 3'd1, 13'h0001, model[1]);
    idle_inputs();
  endtask

  task automatic t_write_isolation();
    step(1'b0, 8'h00, 3'd0, 13'h0, 1'b1, 3'd3, {4{32'hFEEDF00D}});
    for (int k = 2; k <= 4; k++) begin
      step(1'b1, 8'h22, 3'(k), 13'h00AA, 1'b0, 3'd0, '0);
      check_bundle("R5 write targets one register", 8'h22, 3'(k), 13'h00AA, model[k]);
    end
    idle_inputs();
  endtask

  task automatic t_forward();
    logic [127:0] nw;
    nw = {4{32'h0BADCAFE}};
    step(1'b1, 8'h33, 3'd6, 13'h0123, 1'b1, 3'd6, nw);
    check_bundle("R6 forwarded word", 8'h33, 3'd6, 13'h0123, nw);
    step(1'b1, 8'h34, 3'd7, 13'h0042, 1'b1, 3'd0, {4{32'h77777777}});
    check_bundle("R6 no forward on other address", 8'h34, 3'd7, 13'h0042, model[7]);
    step(1'b1, 8'h35, 3'd0, 13'h0007, 1'b0, 3'd0, '0);
    check_bundle("R5 R6 write persisted", 8'h35, 3'd0, 13'h0007, model[0]);
    idle_inputs();
  endtask

  task automatic t_nop();
    step(1'b1, 8'h00, 3'd4, 13'h0ABC, 1'b0, 3'd0, '0);
    check_bundle("R7 no-op", 8'h00, 3'd4, 13'h0ABC, model[4]);
    chk("R7 no-op enables clear", 128'(unit_en), 128'(0));
    step(1'b1, 8'h00, 3'd6, 13'h0001, 1'b1, 3'd6, {4{32'hFFFFFFFF}});
    check_bundle("R7 no-op with forward", 8'h00, 3'd6, 13'h0001, model[6]);
    idle_inputs();
  endtask

  task automatic t_hold();
    step(1'b1, 8'h5C, 3'd2, 13'h0F0F, 1'b0, 3'd0, '0);
    check_bundle("R9 setup", 8'h5C, 3'd2, 13'h0F0F, model[2]);
    step(1'b0, 8'h99, 3'd7, 13'h1111, 1'b0, 3'd0, '0);
    chk("R3 valid drops when idle", 128'(bundle_valid), 128'(0));
    chk("R9 cfg held", bundle_cfg, model[2]);
    chk("R9 opcode held", 128'(bundle_opcode), 128'(8'h5C));
    chk("R9 operands held", 128'(bundle_operands), 128'(13'h0F0F));
    chk("R9 unit_en held", 128'(unit_en), 128'(model[2][7:0]));
    idle_inputs();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_preload_select();
        t_fields();
        t_write_isolation();
        t_forward();
        t_nop();
        t_hold();
      end
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule